// File: doc/BRIEF.md
# Multi-Channel Output Compare Unit

This block watches a shared timebase count and, for each of its channels, compares that count against a programmable 16-bit match value. When an enabled channel sees a match on a cycle in which the timebase advanced, it flips the level of its output pin and latches a request flag. The flag is forwarded as an interrupt only while that channel's interrupt enable is set, and it stays latched until it is cleared.

Channels are grouped in pairs: (0,1), (2,3) and so on. When a pair's combine bit is set, a match on either channel of the pair inverts the pair's even pin. A PWM-like waveform then comes from two match values, one that produces each edge. The odd pin of a combined pair keeps its own behaviour. While a channel is disabled, software can preset its pin to a chosen starting level. The timebase counter is outside the block and arrives as a value plus a one-cycle advance strobe.

Top module: `oc_unit`

## Requirements
- R1: After a synchronous active-low reset, all pins, flags and interrupt outputs are 0, and every match value is 0.
- R2: When channel i is enabled, `cnt_tick` is 1 and `cnt_val` equals channel i's match value, `flag_out[i]` is set at the next clock edge. Its pin is inverted at the same edge, subject to R8 and R9.
- R3: When `cnt_tick` is 0, no match is taken, whatever `cnt_val` holds. A count that is held over several clocks produces exactly one match, on its advance cycle.
- R4: A disabled channel neither inverts any pin nor sets its flag.
- R5: `irq_out[i]` is 1 exactly when `flag_out[i]` is 1 and `irq_en[i]` is 1, in the same cycle, with no register on the way.
- R6: A flag stays 1 until `flag_clr[i]` is high at a clock edge. If a match and a clear occur in the same cycle, the flag stays 1.
- R7: `cmp_we[i]` loads `cmp_wdata` into channel i's match value at the clock edge. Matches on that same cycle still use the old value.
- R8: When `pair_en[p]` is 1, pin 2p inverts on a match of channel 2p or channel 2p+1. If both match in the same cycle, pin 2p is unchanged. Pin 2p+1 still inverts on its own match.
- R9: When `init_we[i]` is 1 and channel i is disabled, pin i takes `init_lvl[i]` at the next edge. This load takes priority over any inversion driven by the partner channel. When channel i is enabled, `init_we[i]` is ignored.
- R10: When `pair_en[p]` is 0, each pin of the pair inverts only on its own channel's match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current timebase count |
| cnt_tick | input | 1 | High on cycles in which the timebase advanced |
| ch_en | input | NCH | Per-channel compare enable |
| cmp_we | input | NCH | Per-channel match value write strobe |
| cmp_wdata | input | CNT_W | Match value to be written |
| irq_en | input | NCH | Per-channel interrupt enable |
| flag_clr | input | NCH | Per-channel flag clear strobe |
| init_we | input | NCH | Per-channel initial-level write strobe |
| init_lvl | input | NCH | Initial pin levels |
| pair_en | input | NCH/2 | Per-pair combine mode |
| pin_out | output | NCH | Pin levels |
| flag_out | output | NCH | Latched match flags |
| irq_out | output | NCH | Interrupt requests |

## Verification
The bench builds the block with its defaults: four channels, meaning two pairs, and a 16-bit count. The two pairs are enough to show that combine mode stays local to its own pair. In the random phase, the count and the match values are kept to a handful of small values. This makes same-cycle double matches within a pair frequent, and so are collisions between a clear, a write or an initial-level load and a match. A wide count would almost never reach these cases.

// File: rtl/oc_pkg.sv
// Shared definitions for the output compare unit.
// Assumes nothing beyond IEEE 1800-2017 packages.
package oc_pkg;

    // Action applied to one pin at the next clock edge.
    typedef enum logic [1:0] {
        PIN_HOLD   = 2'd0,
        PIN_TOGGLE = 2'd1,
        PIN_LOAD   = 2'd2
    } pin_act_e;

endpackage

// File: rtl/oc_chan.sv
// One compare channel: holds a match value, detects a match once per timebase
// advance, and latches a request flag.
// Assumes cnt_tick is high for exactly the cycles on which the count advanced.
module oc_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_i,
    output logic             hit_o,
    output logic             flag_o
);

    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;

    // Match qualified by enable and the advance strobe; uses the stored value.
    always_comb begin
        hit_o = tick_i && en_i && (cnt_i == cmp_q);
    end

    // Match value register, written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= '0;
        else if (we_i) cmp_q <= wdata_i;
    end

    // Request flag: set on a match, cleared on request; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (hit_o) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R2 R4
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(en_i && tick_i && (cnt_i == cmp_q)));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);

    // R7
    cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (cmp_q == $past(wdata_i)));

endmodule

// File: rtl/oc_pin_ctrl.sv
// Pin level register for all channels. Routes match events to pins according
// to the per-pair combine bits and applies initial-level loads.
// Assumes NCH is even; pairs are (0,1), (2,3), ...
module oc_pin_ctrl
    import oc_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hit_i,
    input  logic [NCH/2-1:0] pair_i,
    input  logic [NCH-1:0]   init_ld_i,
    input  logic [NCH-1:0]   init_lvl_i,
    output logic [NCH-1:0]   pin_o
);

    localparam int NP = NCH / 2;

    logic [NCH-1:0] flip;
    pin_act_e       act [NCH];
    logic [NCH-1:0] pin_q;

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_pair
            // Even pin takes the partner's match when combined; odd pin only its own.
            always_comb begin
                flip[2*gp]   = hit_i[2*gp] ^ (pair_i[gp] & hit_i[2*gp+1]);
                flip[2*gp+1] = hit_i[2*gp+1];
            end

            // R8
            pair_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pair_i[gp] && hit_i[2*gp] && hit_i[2*gp+1] && !init_ld_i[2*gp])
                |=> $stable(pin_q[2*gp]));
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_pin
            // Pick the action: a preset load beats an inversion.
            always_comb begin
                if (init_ld_i[gi])  act[gi] = PIN_LOAD;
                else if (flip[gi])  act[gi] = PIN_TOGGLE;
                else                act[gi] = PIN_HOLD;
            end

            // Pin level register.
            always_ff @(posedge clk) begin
                if (!rst_n) pin_q[gi] <= 1'b0;
                else begin
                    case (act[gi])
                        PIN_LOAD:   pin_q[gi] <= init_lvl_i[gi];
                        PIN_TOGGLE: pin_q[gi] <= ~pin_q[gi];
                        default:    pin_q[gi] <= pin_q[gi];
                    endcase
                end
            end

            // R9
            init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
                init_ld_i[gi] |=> (pin_q[gi] == $past(init_lvl_i[gi])));
        end
    endgenerate

    // R3 R10
    pin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i == '0 && init_ld_i == '0) |=> $stable(pin_q));

    assign pin_o = pin_q;

endmodule

// File: rtl/oc_unit.sv
// Output compare unit top: NCH channels against one shared count, pin
// pairing, initial levels and interrupt gating.
// Assumes NCH is even and the count source is outside this block.
module oc_unit #(
    parameter int CNT_W = 16,
    parameter int NCH   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_tick,
    input  logic [NCH-1:0]   ch_en,
    input  logic [NCH-1:0]   cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [NCH-1:0]   irq_en,
    input  logic [NCH-1:0]   flag_clr,
    input  logic [NCH-1:0]   init_we,
    input  logic [NCH-1:0]   init_lvl,
    input  logic [NCH/2-1:0] pair_en,
    output logic [NCH-1:0]   pin_out,
    output logic [NCH-1:0]   flag_out,
    output logic [NCH-1:0]   irq_out
);

    localparam int NP = NCH / 2;

    logic [NCH-1:0] hit;
    logic [NCH-1:0] init_ld;

    genvar gc;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_ch
            oc_chan #(.CNT_W(CNT_W)) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .cnt_i   (cnt_val),
                .tick_i  (cnt_tick),
                .en_i    (ch_en[gc]),
                .we_i    (cmp_we[gc]),
                .wdata_i (cmp_wdata),
                .clr_i   (flag_clr[gc]),
                .hit_o   (hit[gc]),
                .flag_o  (flag_out[gc])
            );
        end
    endgenerate

    // Initial-level writes count only on disabled channels.
    always_comb begin
        init_ld = init_we & ~ch_en;
    end

    oc_pin_ctrl #(.NCH(NCH)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .pair_i     (pair_en[NP-1:0]),
        .init_ld_i  (init_ld),
        .init_lvl_i (init_lvl),
        .pin_o      (pin_out)
    );

    // Interrupt requests are flags gated by their enables, without delay.
    always_comb begin
        irq_out = flag_out & irq_en;
    end

    // R4
    disabled_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en == '0 && init_we == '0) |=> $stable(pin_out));

endmodule

// File: tb/oc_unit_tb.sv
// Bench for oc_unit: directed scenarios with hand-worked values, then a
// random phase; a behavioural model is compared on every clock.
module oc_unit_tb;

    localparam int W = 16;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cnt_val = '0;
    logic         cnt_tick = 1'b0;
    logic [N-1:0] ch_en = '0, cmp_we = '0, irq_en = '0, flag_clr = '0;
    logic [N-1:0] init_we = '0, init_lvl = '0;
    logic [W-1:0] cmp_wdata = '0;
    logic [N/2-1:0] pair_en = '0;
    logic [N-1:0] pin_out, flag_out, irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // model state
    int       m_cmp [N];
    bit [N-1:0] m_pin = '0, m_flag = '0;
    bit       live = 1'b0;

    always #2 clk = ~clk;

    oc_unit #(.CNT_W(W), .NCH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .ch_en(ch_en), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .irq_en(irq_en),
        .flag_clr(flag_clr), .init_we(init_we), .init_lvl(init_lvl),
        .pair_en(pair_en), .pin_out(pin_out), .flag_out(flag_out), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced at every edge.
    always @(posedge clk) begin
        bit [N-1:0] h;
        cycles++;
        if (!rst_n) begin
            m_pin = '0; m_flag = '0;
            for (int i = 0; i < N; i++) m_cmp[i] = 0;
        end else begin
            for (int i = 0; i < N; i++)
                h[i] = cnt_tick && ch_en[i] && (int'(cnt_val) == m_cmp[i]);
            for (int p = 0; p < N/2; p++) begin
                if (h[2*p+1]) m_pin[2*p+1] = ~m_pin[2*p+1];
                if (h[2*p]) m_pin[2*p] = ~m_pin[2*p];
                if (pair_en[p] && h[2*p+1]) m_pin[2*p] = ~m_pin[2*p];
            end
            for (int i = 0; i < N; i++) begin
                if (init_we[i] && !ch_en[i]) m_pin[i] = init_lvl[i];
                if (h[i]) m_flag[i] = 1'b1;
                else if (flag_clr[i]) m_flag[i] = 1'b0;
                if (cmp_we[i]) m_cmp[i] = int'(cmp_wdata);
            end
        end
    end

    // Per-clock comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (live) begin
            chk("R2 R3 R4 R8 R9 R10 pins", 32'(pin_out), 32'(m_pin));
            chk("R2 R6 flags", 32'(flag_out), 32'(m_flag));
            chk("R5 irq", 32'(irq_out), 32'(m_flag & irq_en));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        live = 1'b1;
        // R1 reset state
        chk("R1 pin", 32'(pin_out), 0);
        chk("R1 flag", 32'(flag_out), 0);
        chk("R1 irq", 32'(irq_out), 0);

        // R7 write and match in same cycle uses old value
        ch_en = 4'b0001; cmp_we = 4'b0001; cmp_wdata = 5; cnt_val = 5; cnt_tick = 1;
        cyc(); cmp_we = '0;
        chk("R7 pin", 32'(pin_out), 0);
        cyc();
        chk("R2 pin", 32'(pin_out), 32'h1);
        chk("R2 flag", 32'(flag_out), 32'h1);
        chk("R5 irq off", 32'(irq_out), 0);
        irq_en = 4'b0001; #1;
        chk("R5 irq on", 32'(irq_out), 32'h1);

        // R3 held count does not match again
        cnt_tick = 0;
        repeat (3) cyc();
        chk("R3 pin", 32'(pin_out), 32'h1);

        // R6 set beats clear, then clear
        cnt_tick = 1; flag_clr = 4'b0001;
        cyc();
        chk("R6 set wins", 32'(flag_out), 32'h1);
        chk("R2 toggle back", 32'(pin_out), 0);
        cnt_tick = 0;
        cyc();
        chk("R6 clear", 32'(flag_out), 0);
        flag_clr = '0;

        // R4 disabled channel
        ch_en = '0; cnt_tick = 1;
        cyc();
        chk("R4 pin", 32'(pin_out), 0);
        chk("R4 flag", 32'(flag_out), 0);

        // R9 preset while disabled, ignored while enabled
        cnt_tick = 0; init_we = 4'b0001; init_lvl = 4'b0001;
        cyc();
        chk("R9 load", 32'(pin_out), 32'h1);
        ch_en = 4'b0001; init_lvl = 4'b0000;
        cyc(); init_we = '0;
        chk("R9 ignored", 32'(pin_out), 32'h1);

        // R8 combined pair 0
        pair_en = 2'b01; ch_en = 4'b0011; cmp_we = 4'b0010; cmp_wdata = 7;
        cyc(); cmp_we = '0;
        cnt_val = 7; cnt_tick = 1;
        cyc(); cnt_tick = 0;
        chk("R8 partner inverts", 32'(pin_out), 32'h2);
        cmp_we = 4'b0010; cmp_wdata = 5;
        cyc(); cmp_we = '0;
        cnt_val = 5; cnt_tick = 1;
        cyc();
        chk("R8 double match", 32'(pin_out), 32'h0);

        // R10 separate pair
        pair_en = 2'b00; ch_en = 4'b0010;
        cyc();
        chk("R10 own only", 32'(pin_out), 32'h2);

        // R9 load beats partner inversion
        pair_en = 2'b01; init_we = 4'b0001; init_lvl = 4'b0001;
        cyc(); init_we = '0; cnt_tick = 0;
        chk("R9 priority", 32'(pin_out), 32'h1);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            cnt_val   = W'($urandom_range(0, 5));
            cnt_tick  = 1'($urandom_range(0, 1));
            ch_en     = N'($urandom);
            cmp_we    = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            cmp_wdata = W'($urandom_range(0, 5));
            irq_en    = N'($urandom);
            flag_clr  = ($urandom_range(0, 2) == 0) ? N'($urandom) : '0;
            init_we   = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
            init_lvl  = N'($urandom);
            pair_en   = 2'($urandom);
            cyc();
        end
        cyc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule